// File: doc/BRIEF.md
# Peripheral Request Router

This block sits in front of a DMA engine and decides which peripheral request line drives each DMA channel. Every channel owns one configuration byte: an enable flag and a six-bit source number that picks one of up to 64 request inputs. When a channel is enabled, its request output follows the chosen input. When it is disabled, the output stays low.

The channel bytes are split between two register windows, called banks here. Each bank serves half of the channels. Software addresses a byte with a bank bit and an offset. The channel number is the bank times the channels per bank, plus the offset. So bank 0 holds the lower half of the channels and bank 1 the upper half.

Requests leave through one register stage. Every channel output therefore shows the selected input as it stood at the previous clock edge.

Top module: `req_router`

## Requirements
- R1: After reset, every configuration byte reads 0x00 and every channel request output is 0.
- R2: A write with `cfg_we` high stores bit 7 (enable) and bits 5:0 (source number) of `cfg_wdata` into the addressed byte. `cfg_rdata` returns that byte for the current `cfg_bank`/`cfg_offs` address, with no clock delay.
- R3: Bit 6 of every configuration byte is reserved. It reads as 0 whatever value was written to it.
- R4: The address (`cfg_bank` = b, `cfg_offs` = o) selects channel b*(CHANNELS/2)+o. A write to one bank never changes the byte at the same offset in the other bank.
- R5: While channel c is enabled with source s, `chan_req[c]` after a rising edge equals `src_req[s]` as sampled at that edge. This is one cycle of latency.
- R6: While channel c is disabled, `chan_req[c]` is 0 at every edge, whatever the source inputs do.
- R7: Writing 0x00 to a channel byte disables it. Its output is 0 from the next edge on.
- R8: While `cfg_we` is low, `cfg_wdata` has no effect on any configuration byte.
- R9: Several channels may select the same source, and each of them follows that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_bank | input | 1 | Bank select: lower or upper half of the channels |
| cfg_offs | input | OFF_W | Byte offset within the bank |
| cfg_wdata | input | 8 | Write data: bit 7 enable, bits 5:0 source number |
| cfg_rdata | output | 8 | Read data of the addressed byte, combinational |
| src_req | input | SOURCES | Peripheral request inputs |
| chan_req | output | CHANNELS | Registered request output for each channel |

## Verification
A configuration write takes effect at the edge where `cfg_we` is sampled. Read data is combinational, so the bench reads it back after that edge, once the address settles. A channel output is due one edge after its source is applied. The bench changes inputs only on falling edges and checks `chan_req` on the falling edge after the capturing rising edge. The latency check also confirms that `chan_req` does not follow a source change before the next rising edge.

// File: rtl/req_router.sv
module req_router #(
  parameter int CHANNELS = 8,
  parameter int SOURCES  = 64,
  localparam int PER_BANK = CHANNELS / 2,
  localparam int OFF_W    = (PER_BANK > 1) ? $clog2(PER_BANK) : 1,
  localparam int SEL_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_bank,
  input  logic [OFF_W-1:0]    cfg_offs,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  input  logic [SOURCES-1:0]  src_req,
  output logic [CHANNELS-1:0] chan_req
);

  logic [CHANNELS-1:0] en_q;
  logic [SEL_W-1:0]    sel_q [CHANNELS];
  logic [CHANNELS-1:0] hit;
  logic [CHANNELS-1:0] picked;
  logic [63:0]         src_wide;

  assign src_wide = 64'(src_req);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    localparam int BANK = c / PER_BANK;
    localparam int OFFS = c % PER_BANK;

    assign hit[c]    = (cfg_bank == 1'(BANK)) && (cfg_offs == OFF_W'(OFFS));
    assign picked[c] = (int'(sel_q[c]) < SOURCES) ? src_wide[sel_q[c]] : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[c]  <= 1'b0;
        sel_q[c] <= '0;
      end else if (cfg_we && hit[c]) begin
        en_q[c]  <= cfg_wdata[7];
        sel_q[c] <= cfg_wdata[SEL_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chan_req[c] <= 1'b0;
      else        chan_req[c] <= en_q[c] & picked[c];
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && hit[c]) |=> (en_q[c] == $past(cfg_wdata[7])) && (sel_q[c] == $past(cfg_wdata[5:0])));

    p_hold_no_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(en_q[c]) && $stable(sel_q[c])));

    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[c] |=> !chan_req[c]);

    p_follow_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[c] && int'(sel_q[c]) < SOURCES) |=> (chan_req[c] == $past(src_wide[sel_q[c]])));
  end

  always_comb begin
    cfg_rdata = 8'h00;
    for (int c = 0; c < CHANNELS; c++)
      if (hit[c]) cfg_rdata = {en_q[c], 1'b0, sel_q[c]};
  end

  p_one_hit_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));

  p_rsvd_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> (cfg_rdata[6] == 1'b0));

endmodule

// File: tb/req_router_bench.sv
module req_router_bench;
  localparam int CH = 8;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic          cfg_bank = 1'b0;
  logic [1:0]    cfg_offs = '0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic [NS-1:0] src_req = '0;
  logic [CH-1:0] chan_req;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  req_router #(.CHANNELS(CH), .SOURCES(NS)) u_req_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_offs(cfg_offs), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .src_req(src_req), .chan_req(chan_req)
  );

  // {bank, offs, wdata, src, expected chan_req}
  localparam int NV = 7;
  localparam logic [82:0] TBL [NV] = '{
    {1'b0, 2'd0, 8'h85, 64'h0000_0000_0000_0020, 8'h01},
    {1'b1, 2'd2, 8'hBF, 64'h8000_0000_0000_0020, 8'h41},
    {1'b0, 2'd3, 8'h05, 64'h0000_0000_0000_0020, 8'h01},
    {1'b1, 2'd0, 8'h80, 64'h8000_0000_0000_0001, 8'h50},
    {1'b0, 2'd0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 8'h50},
    {1'b1, 2'd3, 8'hC5, 64'h0000_0000_0000_0020, 8'h80},
    {1'b0, 2'd1, 8'h80, 64'h0000_0000_0000_0001, 8'h12}
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic b, input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    cfg_bank = b; cfg_offs = o; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_cfg(input logic b, input logic [1:0] o, output logic [7:0] d);
    cfg_bank = b; cfg_offs = o;
    #1;
    d = cfg_rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    src_req = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1: reset state of every byte and the outputs
    for (int c = 0; c < CH; c++) begin
      read_cfg(1'(c / 4), 2'(c % 4), rd);
      check8("R1 cfg reset", rd, 8'h00);
    end
    check8("R1 chan_req reset / R6 disabled with all sources high", chan_req, 8'h00);

    // Table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      write_cfg(TBL[i][82], TBL[i][81:80], TBL[i][79:72]);
      read_cfg(TBL[i][82], TBL[i][81:80], rd);
      check8("R2 R3 readback", rd, TBL[i][79:72] & 8'hBF);
      src_req = TBL[i][71:8];
      @(posedge clk);
      @(negedge clk);
      check8("R5 R6 R7 R9 chan_req", chan_req, TBL[i][7:0]);
    end

    // R4: bank 0 offset 2 (ch2) untouched by the bank 1 offset 2 write
    read_cfg(1'b0, 2'd2, rd);
    check8("R4 other bank untouched", rd, 8'h00);
    read_cfg(1'b1, 2'd2, rd);
    check8("R4 upper bank byte", rd, 8'hBF);

    // R8: data with strobe low is ignored
    @(negedge clk);
    cfg_bank = 1'b1; cfg_offs = 2'd0; cfg_wdata = 8'h00; cfg_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    read_cfg(1'b1, 2'd0, rd);
    check8("R8 no write without strobe", rd, 8'h80);
    src_req = 64'h1;
    @(posedge clk);
    @(negedge clk);
    check8("R8 channel still routed", chan_req, 8'h12);

    // R5 latency: output lags the source by one edge
    src_req = 64'h0;
    #1;
    check8("R5 no change before edge", chan_req, 8'h12);
    @(posedge clk);
    @(negedge clk);
    check8("R5 drops after edge", chan_req, 8'h00);

    // R6: disabled ch3 (sel 5) ignores its source
    src_req = 64'h20;
    @(posedge clk);
    @(negedge clk);
    check8("R6 disabled ch3 quiet", chan_req & 8'h08, 8'h00);
    check8("R5 ch7 on source 5", chan_req, 8'h80);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    #1;
    check8("R1 async reset output", chan_req, 8'h00);
    read_cfg(1'b1, 2'd3, rd);
    check8("R1 async reset cfg", rd, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    finish_run();
  end
endmodule